// File: doc/BRIEF.md
# Serial Display Command Receiver

This block accepts a byte stream from a host controller over a three-wire link (data, shift clock, active-low select) and turns it into write strobes for three display memories plus three small control registers. All three link wires are asynchronous to the block. They are brought into the system clock domain, and rising edges of the shift clock are detected there, so the system clock has to run several times faster than the shift clock.

Bits are assembled least-significant first into bytes. The first complete byte after select falls is a command. Its upper nibble selects the operation and its lower nibble carries the argument. Three commands open a RAM write stream: character codes, 16-bit user patterns, or 2-bit symbols. In such a stream every later byte of the frame is data, and the 4-bit address steps forward after each entry and wraps from 15 back to 0. The other commands load the brightness duty, the digit count or the all-lights flags. The memories, scan timing and output drivers sit outside this block. They consume the strobes and register values it produces.

Top module: `dispcmd_rx`

## Requirements
- R1: A bit is taken from `ser_dat` on each rising edge of `ser_clk` while `ser_sel_n` is low. The first bit of a byte lands in byte bit 0, and after eight bits the byte is complete.
- R2: A high level on `ser_sel_n` discards any partial byte and ends any data stream. The first complete byte of the next frame is decoded as a command.
- R3: The command opcode is command bits [7:4]: 4'h1 character write, 4'h2 pattern write, 4'h3 symbol write, 4'h5 duty load, 4'h6 digit-count load, 4'h7 all-lights load.
- R4: A character write starts at address command[3:0]. Each data byte gives one `char_we` pulse with `char_addr` set to the current address and `char_data` set to the byte, and the address then increments, wrapping from 15 to 0.
- R5: A pattern write takes two data bytes per address: pattern bits [7:0] first, then bits [15:8]. One `pat_we` pulse is issued after the second byte, and only then does the address advance (with wrap).
- R6: A symbol write uses data bits [1:0] as `sym_data` and ignores bits [7:2]. The address follows the same increment-and-wrap rule.
- R7: The duty command loads command[3:0] into `duty_q`. The digit-count command loads command[3:0] into `digits_q`, where 0 means 16 digits.
- R8: The all-lights command sets `all_off_q` from command bit 0 and `all_on_q` from command bit 1.
- R9: While `rst_n` is low, the block holds the RAM addresses at 0, `duty_q` at 0, `digits_q` at 0 (16 digits), `all_off_q` at 1 and `all_on_q` at 0, and issues no strobes.
- R10: A command byte with any other opcode changes no register and issues no strobe. After any non-RAM command, the next byte of the same frame is again a command.
- R11: The write strobes are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Host shift clock (asynchronous) |
| ser_dat | input | 1 | Host serial data, LSB first |
| ser_sel_n | input | 1 | Host select, low enables transfer |
| char_we | output | 1 | Character RAM write strobe |
| char_addr | output | 4 | Character RAM address |
| char_data | output | 8 | Character code |
| pat_we | output | 1 | Pattern RAM write strobe |
| pat_addr | output | 4 | Pattern RAM address |
| pat_data | output | 16 | Pattern word |
| sym_we | output | 1 | Symbol RAM write strobe |
| sym_addr | output | 4 | Symbol RAM address |
| sym_data | output | 2 | Symbol bits |
| duty_q | output | 4 | Brightness duty in sixteenths |
| digits_q | output | 4 | Digit count, 0 means 16 |
| all_off_q | output | 1 | Force all outputs low |
| all_on_q | output | 1 | Force all outputs high |

## Verification
The hardest situation to reach is a frame cut short in the middle of a byte or in the middle of a pattern pair, followed by a new frame that must be framed afresh. The stimulus raises select after three bits, and again after only the low byte of a pattern entry. It then opens a new frame and checks that the next byte acts as a command and that no stale half-pattern is written. Address wrap is reached by starting streams at address 14 and running them past 15.

// File: rtl/dispcmd_pkg.sv
package dispcmd_pkg;
   typedef enum logic [3:0] {
      OP_CHAR   = 4'h1,
      OP_PAT    = 4'h2,
      OP_SYM    = 4'h3,
      OP_DUTY   = 4'h5,
      OP_DIGITS = 4'h6,
      OP_LIGHTS = 4'h7
   } opcode_e;

   typedef enum logic [2:0] {
      ST_CMD    = 3'd0,
      ST_CHAR   = 3'd1,
      ST_PAT_LO = 3'd2,
      ST_PAT_HI = 3'd3,
      ST_SYM    = 3'd4
   } rx_state_e;
endpackage

// File: rtl/dispcmd_sync.sv
module dispcmd_sync #(
   parameter int            WIDTH   = 3,
   parameter int            STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/dispcmd_deser.sv
module dispcmd_deser #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              sel_n_s,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_q
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   logic              sclk_d;
   logic              rise;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] shnext;

   assign rise   = sclk_s & ~sclk_d;
   assign shnext = {sdat_s, shreg[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         bit_cnt  <= '0;
         shreg    <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         sclk_d   <= sclk_s;
         byte_vld <= 1'b0;
         if (sel_n_s) begin
            bit_cnt <= '0;
         end else if (rise) begin
            shreg <= shnext;
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               byte_vld <= 1'b1;
               byte_q   <= shnext;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dispcmd_decode.sv
module dispcmd_decode
   import dispcmd_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 4,
   parameter int SYM_W  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel_n_s,
   input  logic                byte_vld,
   input  logic [BYTE_W-1:0]   byte_q,
   output logic                char_we,
   output logic [ADDR_W-1:0]   char_addr,
   output logic [BYTE_W-1:0]   char_data,
   output logic                pat_we,
   output logic [ADDR_W-1:0]   pat_addr,
   output logic [2*BYTE_W-1:0] pat_data,
   output logic                sym_we,
   output logic [ADDR_W-1:0]   sym_addr,
   output logic [SYM_W-1:0]    sym_data,
   output logic [ADDR_W-1:0]   duty_q,
   output logic [ADDR_W-1:0]   digits_q,
   output logic                all_off_q,
   output logic                all_on_q
);
   localparam int OP_W = BYTE_W - ADDR_W;

   rx_state_e         state;
   logic [ADDR_W-1:0] ptr;
   logic [BYTE_W-1:0] lo_hold;
   logic [OP_W-1:0]   op;
   logic [ADDR_W-1:0] arg;

   assign op  = byte_q[BYTE_W-1:ADDR_W];
   assign arg = byte_q[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_CMD;
         ptr       <= '0;
         lo_hold   <= '0;
         char_we   <= 1'b0;
         char_addr <= '0;
         char_data <= '0;
         pat_we    <= 1'b0;
         pat_addr  <= '0;
         pat_data  <= '0;
         sym_we    <= 1'b0;
         sym_addr  <= '0;
         sym_data  <= '0;
         duty_q    <= '0;
         digits_q  <= '0;
         all_off_q <= 1'b1;
         all_on_q  <= 1'b0;
      end else begin
         char_we <= 1'b0;
         pat_we  <= 1'b0;
         sym_we  <= 1'b0;
         if (byte_vld) begin
            unique case (state)
               ST_CMD: begin
                  case (op)
                     OP_CHAR:   begin state <= ST_CHAR;   ptr <= arg; end
                     OP_PAT:    begin state <= ST_PAT_LO; ptr <= arg; end
                     OP_SYM:    begin state <= ST_SYM;    ptr <= arg; end
                     OP_DUTY:   duty_q   <= arg;
                     OP_DIGITS: digits_q <= arg;
                     OP_LIGHTS: begin
                        all_off_q <= byte_q[0];
                        all_on_q  <= byte_q[1];
                     end
                     default: ;
                  endcase
               end
               ST_CHAR: begin
                  char_we   <= 1'b1;
                  char_addr <= ptr;
                  char_data <= byte_q;
                  ptr       <= ptr + 1'b1;
               end
               ST_PAT_LO: begin
                  lo_hold <= byte_q;
                  state   <= ST_PAT_HI;
               end
               ST_PAT_HI: begin
                  pat_we   <= 1'b1;
                  pat_addr <= ptr;
                  pat_data <= {byte_q, lo_hold};
                  ptr      <= ptr + 1'b1;
                  state    <= ST_PAT_LO;
               end
               ST_SYM: begin
                  sym_we   <= 1'b1;
                  sym_addr <= ptr;
                  sym_data <= byte_q[SYM_W-1:0];
                  ptr      <= ptr + 1'b1;
               end
               default: state <= ST_CMD;
            endcase
         end else if (sel_n_s) begin
            state <= ST_CMD;
         end
      end
   end
endmodule

// File: rtl/dispcmd_rx.sv
module dispcmd_rx #(
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYM_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ser_clk,
   input  logic        ser_dat,
   input  logic        ser_sel_n,
   output logic        char_we,
   output logic [3:0]  char_addr,
   output logic [7:0]  char_data,
   output logic        pat_we,
   output logic [3:0]  pat_addr,
   output logic [15:0] pat_data,
   output logic        sym_we,
   output logic [3:0]  sym_addr,
   output logic [1:0]  sym_data,
   output logic [3:0]  duty_q,
   output logic [3:0]  digits_q,
   output logic        all_off_q,
   output logic        all_on_q
);
   localparam int PAT_W = 2 * BYTE_W;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("dispcmd_rx: BYTE_W must be 8");
   end
   if (ADDR_W != 4) begin : g_bad_addr
      $error("dispcmd_rx: ADDR_W must be 4");
   end
   if (SYM_W < 1 || SYM_W > BYTE_W) begin : g_bad_sym
      $error("dispcmd_rx: SYM_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dispcmd_rx: SYNC_STAGES must be at least 2");
   end

   logic [2:0]        s_vec;
   logic              byte_vld;
   logic [BYTE_W-1:0] byte_q;

   dispcmd_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in({ser_sel_n, ser_dat, ser_clk}),
      .sync_out(s_vec)
   );

   dispcmd_deser #(.BYTE_W(BYTE_W)) u_deser (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (s_vec[0]),
      .sdat_s  (s_vec[1]),
      .sel_n_s (s_vec[2]),
      .byte_vld(byte_vld),
      .byte_q  (byte_q)
   );

   dispcmd_decode #(
      .BYTE_W(BYTE_W),
      .ADDR_W(ADDR_W),
      .SYM_W (SYM_W)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n_s  (s_vec[2]),
      .byte_vld (byte_vld),
      .byte_q   (byte_q),
      .char_we  (char_we),
      .char_addr(char_addr),
      .char_data(char_data),
      .pat_we   (pat_we),
      .pat_addr (pat_addr),
      .pat_data (pat_data[PAT_W-1:0]),
      .sym_we   (sym_we),
      .sym_addr (sym_addr),
      .sym_data (sym_data),
      .duty_q   (duty_q),
      .digits_q (digits_q),
      .all_off_q(all_off_q),
      .all_on_q (all_on_q)
   );
endmodule

// File: rtl/dispcmd_rx_chk.sv
module dispcmd_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       char_we,
   input logic       pat_we,
   input logic       sym_we,
   input logic [3:0] char_addr,
   input logic [3:0] duty_q,
   input logic [3:0] digits_q,
   input logic       all_off_q,
   input logic       all_on_q
);
   // R11: never two strobes together
   a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({char_we, pat_we, sym_we}));

   // R11: character strobe lasts one cycle
   a_r11_char_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      char_we |=> !char_we);

   // R11: pattern strobe lasts one cycle
   a_r11_pat_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pat_we |=> !pat_we);

   // R11: symbol strobe lasts one cycle
   a_r11_sym_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sym_we |=> !sym_we);

   // R9: state right after reset release
   a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (duty_q == 4'd0 && digits_q == 4'd0 && all_off_q
                        && !all_on_q && char_addr == 4'd0 && !char_we));

   // R10: control registers never change in a cycle that carries a RAM strobe
   a_r10_reg_vs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (char_we || pat_we || sym_we) |-> ($stable(duty_q) && $stable(digits_q)
                                         && $stable(all_off_q) && $stable(all_on_q)));
endmodule

bind dispcmd_rx dispcmd_rx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .char_we  (char_we),
   .pat_we   (pat_we),
   .sym_we   (sym_we),
   .char_addr(char_addr),
   .duty_q   (duty_q),
   .digits_q (digits_q),
   .all_off_q(all_off_q),
   .all_on_q (all_on_q)
);

// File: tb/dispcmd_rx_tb.sv
module dispcmd_rx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BIT   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_dat = 1'b0;
   logic ser_sel_n = 1'b1;
   logic        char_we, pat_we, sym_we, all_off_q, all_on_q;
   logic [3:0]  char_addr, pat_addr, sym_addr, duty_q, digits_q;
   logic [7:0]  char_data;
   logic [15:0] pat_data;
   logic [1:0]  sym_data;

   int checks = 0;
   int errors = 0;
   bit quiet  = 1'b0;
   bit done   = 1'b0;

   int m_mode = 0;
   int m_addr = 0;
   int m_lo   = 0;
   int e_duty = 0, e_digits = 0, e_off = 1, e_on = 0;
   int q_kind[$];
   int q_addr[$];
   int q_data[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dispcmd_rx u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_sel_n(ser_sel_n),
      .char_we(char_we), .char_addr(char_addr), .char_data(char_data),
      .pat_we(pat_we), .pat_addr(pat_addr), .pat_data(pat_data),
      .sym_we(sym_we), .sym_addr(sym_addr), .sym_data(sym_data),
      .duty_q(duty_q), .digits_q(digits_q),
      .all_off_q(all_off_q), .all_on_q(all_on_q)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: byte-level command interpreter
   task automatic model_byte(input int b);
      case (m_mode)
         0: begin
            case ((b >> 4) & 15)
               1: begin m_mode = 1; m_addr = b & 15; end
               2: begin m_mode = 2; m_addr = b & 15; end
               3: begin m_mode = 4; m_addr = b & 15; end
               5: e_duty = b & 15;
               6: e_digits = b & 15;
               7: begin e_off = b & 1; e_on = (b >> 1) & 1; end
               default: ;
            endcase
         end
         1: begin
            q_kind.push_back(1); q_addr.push_back(m_addr); q_data.push_back(b);
            m_addr = (m_addr + 1) % 16;
         end
         2: begin m_lo = b; m_mode = 3; end
         3: begin
            q_kind.push_back(2); q_addr.push_back(m_addr); q_data.push_back(b * 256 + m_lo);
            m_addr = (m_addr + 1) % 16;
            m_mode = 2;
         end
         default: begin
            q_kind.push_back(3); q_addr.push_back(m_addr); q_data.push_back(b % 4);
            m_addr = (m_addr + 1) % 16;
         end
      endcase
   endtask

   task automatic send_bit(input logic v);
      @(negedge clk); ser_dat = v;
      repeat (HALF_BIT) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF_BIT) @(negedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic send_byte(input int b);
      quiet = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i == 7) model_byte(b);
         send_bit(logic'((b >> i) & 1));
      end
      repeat (8) @(negedge clk);
      quiet = 1'b1;
   endtask

   task automatic frame_start();
      quiet = 1'b0;
      @(negedge clk); ser_sel_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic frame_end();
      quiet = 1'b0;
      @(negedge clk); ser_sel_n = 1'b1;
      m_mode = 0;
      repeat (8) @(negedge clk);
      quiet = 1'b1;
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (!rst_n) begin
         check(!char_we && !pat_we && !sym_we, "R9", {char_we, pat_we, sym_we}, 0);
         check(duty_q == 0 && digits_q == 0 && all_off_q && !all_on_q && char_addr == 0,
               "R9", {duty_q, digits_q, all_off_q, all_on_q}, 4'h0 << 6 | 2'b10);
      end else begin
         check((char_we + pat_we + sym_we) <= 1, "R11", {char_we, pat_we, sym_we}, 1);
         if (char_we || pat_we || sym_we) begin
            if (q_kind.size() == 0) begin
               check(1'b0, "R10", {char_we, pat_we, sym_we}, 0);
            end else begin
               int k, a, d;
               k = q_kind.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
               if (k == 1) begin
                  check(char_we, "R3", {char_we, pat_we, sym_we}, 3'b100);
                  check(char_addr == a[3:0] && char_data == d[7:0], "R4",
                        {char_addr, char_data}, a * 256 + d);
               end else if (k == 2) begin
                  check(pat_we, "R3", {char_we, pat_we, sym_we}, 3'b010);
                  check(pat_addr == a[3:0] && pat_data == d[15:0], "R5",
                        {pat_addr, pat_data}, a * 65536 + d);
               end else begin
                  check(sym_we, "R3", {char_we, pat_we, sym_we}, 3'b001);
                  check(sym_addr == a[3:0] && sym_data == d[1:0], "R6",
                        {sym_addr, sym_data}, a * 4 + d);
               end
            end
         end
         if (quiet) begin
            check(duty_q == e_duty[3:0], "R7", duty_q, e_duty);
            check(digits_q == e_digits[3:0], "R7", digits_q, e_digits);
            check(all_off_q == e_off[0] && all_on_q == e_on[0], "R8",
                  {all_off_q, all_on_q}, e_off * 2 + e_on);
         end
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      quiet = 1'b1;

      // R7 and R8: control commands, several in one frame
      frame_start();
      send_byte(8'h5A);
      send_byte(8'h63);
      send_byte(8'h72);
      frame_end();
      frame_start();
      send_byte(8'h71);
      send_byte(8'h70);
      frame_end();

      // R4 and R1: character stream starting at 14 wraps past 15
      frame_start();
      send_byte(8'h1E);
      send_byte(8'hA5);
      send_byte(8'h3C);
      send_byte(8'h01);
      send_byte(8'h80);
      frame_end();

      // R5: pattern pairs with wrap
      frame_start();
      send_byte(8'h2F);
      send_byte(8'h34);
      send_byte(8'h12);
      send_byte(8'hCD);
      send_byte(8'hAB);
      frame_end();

      // R6: symbol data with upper bits set
      frame_start();
      send_byte(8'h37);
      send_byte(8'hFE);
      send_byte(8'h55);
      send_byte(8'hAB);
      frame_end();

      // R10: unknown opcodes leave everything unchanged
      frame_start();
      send_byte(8'hF5);
      send_byte(8'h0C);
      send_byte(8'h93);
      frame_end();

      // R2: partial byte discarded, new frame decodes a command
      frame_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      frame_end();
      frame_start();
      send_byte(8'h59);
      frame_end();

      // R2: pattern frame cut after low byte; next frame is a command
      frame_start();
      send_byte(8'h24);
      send_byte(8'h77);
      frame_end();
      frame_start();
      send_byte(8'h6B);
      send_byte(8'h11);
      frame_end();

      repeat (20) @(negedge clk);
      check(q_kind.size() == 0, "R4", q_kind.size(), 0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(negedge clk);
            check(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule